// File: doc/BRIEF.md
# Quadrature Encoder to Up/Down Strobe Converter

This block takes the two phase outputs of an incremental encoder and turns them into two idle-high, active-low count strobes: one for forward steps and one for reverse steps. The strobes are meant to drive a counter that has separate up and down clock inputs. Everything runs from one free-running system clock. Each phase input passes through a two-flop synchronizer and a minimum-width filter. The filtered 2-bit state is then decoded into direction and count events at a selectable resolution.

Each count event fires a one-shot whose low time is a programmed number of system clocks. Events that arrive while a strobe is still low are held in a small per-line pending counter and replayed later, so no step is lost. A jump in which both phases change in the same filtered sample is not counted. Instead it sets a sticky error flag, which only reset clears.

Top module: `quad_pulse_gen`

## Requirements
- R1: `res_mode` picks the resolution. 2'b00 (x1) emits one strobe per full quadrature cycle, on the rising edge of A only. 2'b01 (x2) emits one strobe on every edge of A. 2'b10 (x4) emits one strobe on every single-phase change of the {A,B} state. 2'b11 behaves as x4.
- R2: A change that follows the sequence {A,B} = 00→10→11→01→00 (A leads B) pulses only `up_n`. The reverse sequence 00→01→11→10→00 (B leads A) pulses only `dn_n`.
- R3: While `rst` is high (synchronous, active high), both strobes are high and `jump_err` is 0. The filtered state present during reset becomes the reference for later changes, and reset itself produces no strobe.
- R4: Each strobe stays low for exactly `pulse_len` clocks. A value of 0 acts as 1.
- R5: A level on A or B that lasts fewer than FILT_CYC clocks is ignored. A level that lasts FILT_CYC clocks or more is accepted. There is no upper limit on level length.
- R6: Exchanging the A and B connections swaps which strobe line reports a given motion.
- R7: When both phases change in one filtered sample, no strobe is produced and `jump_err` goes to 1. It stays at 1 until reset.
- R8: An event that arrives while its strobe is low is queued, up to 2^PEND_W-1 pending per line. It is emitted after the current strobe ends. Consecutive strobes on one line are separated by at least one high clock, and in back-to-back operation by exactly one.
- R9: When an input changes between clock edges, the strobe's falling edge appears at the (FILT_CYC+3)-th rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| res_mode | input | 2 | Resolution select (00 x1, 01 x2, 10/11 x4) |
| pulse_len | input | PW_W | Strobe low time in clocks |
| up_n | output | 1 | Forward count strobe, active low |
| dn_n | output | 1 | Reverse count strobe, active low |
| jump_err | output | 1 | Sticky illegal-transition flag |

## Verification
The main sweep runs whole quadrature cycles in both directions under all four mode codes and two strobe widths. It counts falling edges on each line against the number of cycles times the resolution factor, which separates the x1, x2 and x4 decimation rules and the direction split. Running the same forward sequence with the phases exchanged shows that only wiring decides direction. Input levels one clock shorter than the filter window and exactly as long as it locate the filter threshold. Slow states combined with a long strobe force queueing, which exposes lost events and a wrong inter-pulse gap. A double-phase jump, followed by reset at a non-zero state, tests the error flag and how the reference is loaded.

// File: rtl/qpg_pkg.sv
package qpg_pkg;
  typedef enum logic [1:0] {
    RES_X1  = 2'b00,
    RES_X2  = 2'b01,
    RES_X4  = 2'b10,
    RES_X4B = 2'b11
  } res_e;
endpackage

// File: rtl/qpg_filter.sv
module qpg_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC) + 1;

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    s1 <= raw;
    s2 <= s1;
  end

  // A new level is taken only after FILT_CYC consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      clean <= s2;
      cnt   <= '0;
    end else if (s2 == clean) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_CYC - 1)) begin
      clean <= s2;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_filt_src_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean) |-> (clean == $past(s2)));
endmodule

// File: rtl/qpg_decode.sv
module qpg_decode
  import qpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cur,     // {A, B}, filtered
  input  res_e       mode,
  output logic       up_ev,
  output logic       dn_ev,
  output logic       err
);
  logic [1:0] prev;
  logic       da, db, fwd, qual;

  always_comb begin
    da  = cur[1] ^ prev[1];
    db  = cur[0] ^ prev[0];
    // A moving away from B, or B moving onto A, means A leads B.
    fwd = da ? (cur[1] ^ cur[0]) : ~(cur[1] ^ cur[0]);
    unique case (mode)
      RES_X1:  qual = da & ~db & cur[1];
      RES_X2:  qual = da & ~db;
      default: qual = da ^ db;
    endcase
    up_ev = ~rst & qual & fwd;
    dn_ev = ~rst & qual & ~fwd;
  end

  always_ff @(posedge clk) begin
    prev <= cur;                      // reset also loads the reference (R3)
    if (rst)            err <= 1'b0;
    else if (da && db)  err <= 1'b1;
  end

  assert_jump_flag_R7: assert property (@(posedge clk) disable iff (rst)
    ((cur ^ prev) == 2'b11) |=> err);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  assert_x2_only_a_R1: assert property (@(posedge clk) disable iff (rst)
    ((mode == RES_X2) && (up_ev || dn_ev)) |-> (cur[1] != prev[1]));
endmodule

// File: rtl/qpg_shaper.sv
module qpg_shaper #(
  parameter int PW_W   = 8,
  parameter int PEND_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev,
  input  logic [PW_W-1:0] width,
  output logic            strobe_n
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              busy, start;
  logic [PW_W-1:0]   cnt;
  logic [PEND_W-1:0] pend;

  assign start    = ~busy & (ev | (pend != '0));
  assign strobe_n = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      pend <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= (width == '0) ? PW_W'(1) : width;
      end else if (busy) begin
        if (cnt == PW_W'(1)) busy <= 1'b0;
        else                 cnt  <= cnt - 1'b1;
      end
      unique case ({ev, start})
        2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    ((pend == PEND_MAX) && ev) |-> start);
  assert_start_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(ev) || ($past(pend) != '0)));
  assert_width_end_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && (cnt == PW_W'(1))) |=> (!busy || $past(start)));
endmodule

// File: rtl/quad_pulse_gen.sv
module quad_pulse_gen
  import qpg_pkg::*;
#(
  parameter int FILT_CYC = 8,
  parameter int PW_W     = 8,
  parameter int PEND_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enc_a,
  input  logic            enc_b,
  input  logic [1:0]      res_mode,
  input  logic [PW_W-1:0] pulse_len,
  output logic            up_n,
  output logic            dn_n,
  output logic            jump_err
);
  localparam int NPH = 2;

  logic [NPH-1:0] raw_ab, clean_ab;
  logic [NPH-1:0] ev_vec, strobe_vec;
  logic           up_ev, dn_ev;

  assign raw_ab = {enc_a, enc_b};

  for (genvar g = 0; g < NPH; g++) begin : g_filt
    qpg_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst(rst), .raw(raw_ab[g]), .clean(clean_ab[g])
    );
  end

  qpg_decode u_dec (
    .clk(clk), .rst(rst), .cur(clean_ab), .mode(res_e'(res_mode)),
    .up_ev(up_ev), .dn_ev(dn_ev), .err(jump_err)
  );

  assign ev_vec = {up_ev, dn_ev};

  // Latency (R9): 2 sync flops + FILT_CYC filter samples + strobe register.
  for (genvar g = 0; g < NPH; g++) begin : g_shape
    qpg_shaper #(.PW_W(PW_W), .PEND_W(PEND_W)) u_shape (
      .clk(clk), .rst(rst), .ev(ev_vec[g]), .width(pulse_len),
      .strobe_n(strobe_vec[g])
    );
  end

  assign up_n = strobe_vec[1];
  assign dn_n = strobe_vec[0];
endmodule

// File: tb/quad_pulse_gen_bench.sv
module quad_pulse_gen_bench;
  localparam int F = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a = 1'b0, b = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [7:0] plen = 8'd4;
  logic       up_n, dn_n, jump_err;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  int   falls[2], run_lo[2], run_hi[2], wmin[2], wmax[2], gmin[2];
  logic last[2];
  bit   seen[2];
  logic mv;

  always #2 clk = ~clk;

  quad_pulse_gen #(.FILT_CYC(F), .PW_W(8), .PEND_W(4)) u_quad_pulse_gen (
    .clk(clk), .rst(rst), .enc_a(a), .enc_b(b), .res_mode(mode),
    .pulse_len(plen), .up_n(up_n), .dn_n(dn_n), .jump_err(jump_err)
  );

  // Line 0 = up_n, line 1 = dn_n.
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      mv = (i == 0) ? up_n : dn_n;
      if (!mv) begin
        if (last[i]) begin
          falls[i]++;
          if (seen[i] && run_hi[i] < gmin[i]) gmin[i] = run_hi[i];
        end
        run_lo[i]++;
      end else begin
        if (last[i] === 1'b0) begin
          if (run_lo[i] < wmin[i]) wmin[i] = run_lo[i];
          if (run_lo[i] > wmax[i]) wmax[i] = run_lo[i];
          run_lo[i] = 0;
          run_hi[i] = 0;
          seen[i]   = 1'b1;
        end
        run_hi[i]++;
      end
      last[i] = mv;
    end
  end

  task automatic clear_mon();
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      falls[i] = 0; run_lo[i] = 0; run_hi[i] = 0;
      wmin[i] = 1000; wmax[i] = 0; gmin[i] = 1000; seen[i] = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_ab(input logic x, input logic y, input bit swap, input int hold);
    @(posedge clk); #1;
    if (swap) begin a = y; b = x; end
    else      begin a = x; b = y; end
    repeat (hold - 1) @(posedge clk);
  endtask

  task automatic quad_cycles(input bit fwd, input int n, input int hold, input bit swap);
    for (int c = 0; c < n; c++) begin
      if (fwd) begin
        set_ab(1, 0, swap, hold); set_ab(1, 1, swap, hold);
        set_ab(0, 1, swap, hold); set_ab(0, 0, swap, hold);
      end else begin
        set_ab(0, 1, swap, hold); set_ab(1, 1, swap, hold);
        set_ab(1, 0, swap, hold); set_ab(0, 0, swap, hold);
      end
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (6) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int widths[2];
    widths[0] = 1; widths[1] = 4;
    for (int i = 0; i < 2; i++) last[i] = 1'b1;
    clear_mon();
    repeat (6) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(up_n && dn_n, "R3 strobes idle after reset", {up_n, dn_n}, 3);
    check(!jump_err, "R3 error clear after reset", jump_err, 0);
    check(falls[0] + falls[1] == 0, "R3 no strobe from reset", falls[0] + falls[1], 0);

    // R1 / R2 / R4 sweep
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < 2; w++) begin
          int factor, exp_up, exp_dn, ln;
          mode = 2'(m); plen = 8'(widths[w]);
          factor = (m == 0) ? 1 : (m == 1) ? 2 : 4;
          clear_mon();
          quad_cycles(d == 0, 3, 12, 1'b0);
          repeat (40) @(posedge clk);
          exp_up = (d == 0) ? 3 * factor : 0;
          exp_dn = (d == 0) ? 0 : 3 * factor;
          check(falls[0] == exp_up, "R1 R2 up strobe count", falls[0], exp_up);
          check(falls[1] == exp_dn, "R1 R2 down strobe count", falls[1], exp_dn);
          ln = (d == 0) ? 0 : 1;
          check(wmin[ln] == widths[w] && wmax[ln] == widths[w],
                "R4 strobe width", (wmin[ln] == widths[w]) ? wmax[ln] : wmin[ln], widths[w]);
        end
      end
    end

    // R6 swap
    mode = 2'b10; plen = 8'd3;
    clear_mon();
    quad_cycles(1'b1, 3, 12, 1'b1);
    repeat (40) @(posedge clk);
    check(falls[1] == 12, "R6 swapped wiring on down line", falls[1], 12);
    check(falls[0] == 0, "R6 swapped wiring up line quiet", falls[0], 0);

    // R9 latency
    clear_mon();
    @(posedge clk); #1 a = 1'b1;
    k = 0;
    while (k < 60) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (!up_n) break;
    end
    check(k == F + 3, "R9 input to strobe latency", k, F + 3);
    repeat (20) @(posedge clk);
    #1 a = 1'b0;
    repeat (40) @(posedge clk);

    // R5 filter threshold
    clear_mon();
    @(posedge clk); #1 a = 1'b1;
    repeat (F - 1) @(posedge clk);
    #1 a = 1'b0;
    repeat (40) @(posedge clk);
    check(falls[0] + falls[1] == 0, "R5 short level rejected", falls[0] + falls[1], 0);
    clear_mon();
    @(posedge clk); #1 a = 1'b1;
    repeat (F) @(posedge clk);
    #1 a = 1'b0;
    repeat (40) @(posedge clk);
    check(falls[0] == 1 && falls[1] == 1, "R5 full-width level accepted",
          falls[0] * 10 + falls[1], 11);

    // R8 queueing
    plen = 8'd30;
    clear_mon();
    quad_cycles(1'b1, 2, 10, 1'b0);
    repeat (320) @(posedge clk);
    check(falls[0] == 8, "R8 queued events all emitted", falls[0], 8);
    check(wmin[0] == 30 && wmax[0] == 30, "R8 R4 queued strobe width", wmax[0], 30);
    check(gmin[0] == 1, "R8 one idle clock between queued strobes", gmin[0], 1);

    // R7 illegal jump
    plen = 8'd3;
    clear_mon();
    set_ab(1, 1, 1'b0, 20);
    repeat (20) @(posedge clk);
    check(falls[0] + falls[1] == 0, "R7 jump gives no strobe", falls[0] + falls[1], 0);
    check(jump_err == 1'b1, "R7 jump sets flag", jump_err, 1);
    repeat (30) @(posedge clk);
    check(jump_err == 1'b1, "R7 flag sticky", jump_err, 1);

    // R3 reset at state 11 loads reference
    do_reset();
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(!jump_err, "R3 reset clears flag", jump_err, 0);
    check(falls[0] + falls[1] == 0, "R3 reset emits nothing", falls[0] + falls[1], 0);
    clear_mon();
    set_ab(0, 1, 1'b0, 12);
    repeat (30) @(posedge clk);
    check(falls[0] == 1 && falls[1] == 0, "R3 R2 reference after reset",
          falls[0] * 10 + falls[1], 10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule